// File: doc/BRIEF.md
# Parallel Port Reverse Nibble Receiver

This block is the host-side engine that pulls one byte from a peripheral over the reverse channel of a parallel port. The eight data lines are not used. The peripheral instead places four bits at a time on four status inputs, and the two sides trade an interlocked handshake. The host lowers its busy output to ask for a nibble. The peripheral lowers its clock line when the nibble is valid. The host captures the nibble and raises busy again. The peripheral then releases its clock. Two such exchanges, with the low nibble first, make up one byte.

On the system side a one-cycle request starts a byte read. Once the second nibble has been captured and its handshake has closed, the block returns the assembled byte with a one-cycle valid strobe. All peripheral inputs pass through a two-flop synchroniser. A programmable watchdog aborts a read when the peripheral clock stops changing. On an abort the block raises a one-cycle timeout flag and releases the handshake.

Top module: `pp_nibble_rx`

## Requirements
- R1: `xfer_active_o` goes high in the cycle after an accepted request and stays high until the byte completes, a timeout occurs or reset is applied. It is low whenever the engine is idle.
- R2: `host_busy_o` goes low when the engine is ready for a nibble. It stays low for as long as `per_clk_i` stays high.
- R3: A falling edge on `per_clk_i` raises `host_busy_o` exactly three clocks after the input changes. The next nibble is requested only after `per_clk_i` has returned high.
- R4: Bit mapping of `per_nib_i`: bit 0 is the line that carries byte bits 0 and 4, bit 1 carries bits 1 and 5, bit 2 carries bits 2 and 6, and bit 3 carries bits 3 and 7.
- R5: The first nibble of a byte forms `byte_o[3:0]` and the second forms `byte_o[7:4]`.
- R6: `fwd_strobe_n_o` and `periph_reset_n_o` stay high at all times, because the forward strobe and the peripheral reset take no part in a reverse read.
- R7: Nibble data is taken at the synchronised falling edge of `per_clk_i`. Changes to `per_nib_i` after `host_busy_o` has risen do not alter the result.
- R8: If `per_clk_i` stays unchanged for about `timeout_lim_i` clocks while a read is in progress, `timeout_o` pulses for one cycle. In that same cycle `host_busy_o` is high, `xfer_active_o` is low and no byte is returned.
- R9: `byte_vld_o` is high for exactly one cycle, three clocks after `per_clk_i` returns high at the end of the second nibble. `byte_o` holds the assembled byte in that cycle.
- R10: A `timeout_lim_i` value of 0 turns the watchdog off. A read then waits for the peripheral without limit.
- R11: `req_i` is ignored while a read is in progress. It neither restarts the read nor queues a second one.
- R12: Synchronous reset forces `host_busy_o` high, `xfer_active_o` low, and `byte_vld_o` and `timeout_o` low, including when reset arrives in the middle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | One-cycle pulse that starts a byte read |
| timeout_lim_i | input | CNT_W | Watchdog limit in clocks; 0 turns the watchdog off |
| byte_o | output | 8 | Assembled byte |
| byte_vld_o | output | 1 | One-cycle strobe marking `byte_o` valid |
| timeout_o | output | 1 | One-cycle abort flag |
| per_clk_i | input | 1 | Peripheral nibble clock, low means data valid |
| per_nib_i | input | 4 | Four status lines that carry the nibble |
| host_busy_o | output | 1 | Host handshake, low means ready for a nibble |
| xfer_active_o | output | 1 | High while the host is in a reverse transfer |
| fwd_strobe_n_o | output | 1 | Forward data strobe, held inactive (high) |
| periph_reset_n_o | output | 1 | Peripheral reset, held inactive (high) |

## Verification
Each reaction to a peripheral edge is due three clocks after the input changes. Two of those clocks are the synchroniser stages and the third is the state register. So `host_busy_o` rises on the third clock after `per_clk_i` falls, and `byte_vld_o` appears on the third clock after the final release. The bench drives inputs on the falling clock edge and counts falling edges until it sees the response, then compares the count with three. Timeouts are measured the same way, but are accepted within a small window above the programmed limit, because entry into and exit from the wait state each add a cycle.

// File: rtl/pp_nib_pkg.sv
package pp_nib_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  typedef enum logic [1:0] {
    ST_IDLE         = 2'd0,
    ST_WAIT_VALID   = 2'd1,
    ST_WAIT_RELEASE = 2'd2
  } nib_state_t;
endpackage

// File: rtl/pp_nib_sync.sv
module pp_nib_sync #(
  parameter int             W       = 5,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pp_nib_edge.sv
module pp_nib_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic fall_o,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;
  assign rise_o = ~prev_q & lvl_i;
endmodule

// File: rtl/pp_nib_wdog.sv
module pp_nib_wdog #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || kick_i)                  cnt_q <= '0;
    else if (run_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (lim_i != '0) && (cnt_q >= lim_i);
endmodule

// File: rtl/pp_nibble_rx.sv
module pp_nibble_rx
  import pp_nib_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [CNT_W-1:0]  timeout_lim_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              timeout_o,
  input  logic              per_clk_i,
  input  logic [NIB_W-1:0]  per_nib_i,
  output logic              host_busy_o,
  output logic              xfer_active_o,
  output logic              fwd_strobe_n_o,
  output logic              periph_reset_n_o
);
  localparam int IN_W = NIB_W + 1;
  localparam logic [IN_W-1:0] IN_RST = {1'b1, {NIB_W{1'b0}}};

  logic [IN_W-1:0]  in_s;
  logic             clk_s, clk_fall, clk_rise, expired;
  logic [NIB_W-1:0] nib_s, lo_q, hi_q;
  nib_state_t       state_q;
  logic             second_q, hbusy_q, act_q, vld_q, to_q;
  logic [BYTE_W-1:0] byte_q;

  pp_nib_sync #(.W(IN_W), .STAGES(SYNC_STGS), .RST_VAL(IN_RST)) u_sync (
    .clk(clk), .rst(rst), .d_i({per_clk_i, per_nib_i}), .q_o(in_s)
  );

  assign clk_s = in_s[IN_W-1];
  assign nib_s = in_s[NIB_W-1:0];

  pp_nib_edge u_edge (
    .clk(clk), .rst(rst), .lvl_i(clk_s), .fall_o(clk_fall), .rise_o(clk_rise)
  );

  pp_nib_wdog #(.CNT_W(CNT_W)) u_wdog (
    .clk(clk), .rst(rst),
    .run_i(state_q != ST_IDLE),
    .kick_i((state_q == ST_IDLE) || clk_fall || clk_rise),
    .lim_i(timeout_lim_i),
    .expired_o(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      second_q <= 1'b0;
      hbusy_q  <= 1'b1;
      act_q    <= 1'b0;
      vld_q    <= 1'b0;
      to_q     <= 1'b0;
      lo_q     <= '0;
      hi_q     <= '0;
      byte_q   <= '0;
    end else begin
      vld_q <= 1'b0;
      to_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            state_q  <= ST_WAIT_VALID;
            second_q <= 1'b0;
            act_q    <= 1'b1;
            hbusy_q  <= 1'b0;
          end
        end
        ST_WAIT_VALID: begin
          if (clk_fall) begin
            hbusy_q <= 1'b1;
            state_q <= ST_WAIT_RELEASE;
            if (second_q) hi_q <= nib_s;
            else          lo_q <= nib_s;
          end else if (expired) begin
            to_q    <= 1'b1;
            hbusy_q <= 1'b1;
            act_q   <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        ST_WAIT_RELEASE: begin
          if (clk_rise) begin
            if (!second_q) begin
              second_q <= 1'b1;
              hbusy_q  <= 1'b0;
              state_q  <= ST_WAIT_VALID;
            end else begin
              byte_q  <= {hi_q, lo_q};
              vld_q   <= 1'b1;
              act_q   <= 1'b0;
              state_q <= ST_IDLE;
            end
          end else if (expired) begin
            to_q    <= 1'b1;
            hbusy_q <= 1'b1;
            act_q   <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign byte_o           = byte_q;
  assign byte_vld_o       = vld_q;
  assign timeout_o        = to_q;
  assign host_busy_o      = hbusy_q;
  assign xfer_active_o    = act_q;
  assign fwd_strobe_n_o   = 1'b1;
  assign periph_reset_n_o = 1'b1;
endmodule

// File: rtl/pp_nibble_rx_chk.sv
module pp_nibble_rx_chk (
  input logic clk,
  input logic rst,
  input logic req_i,
  input logic host_busy_o,
  input logic xfer_active_o,
  input logic byte_vld_o,
  input logic timeout_o,
  input logic clk_fall
);
  AST_BUSY_LOW_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    !host_busy_o |-> xfer_active_o); // R1

  AST_ACTIVE_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(xfer_active_o) |-> $past(req_i)); // R11

  AST_BUSY_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(host_busy_o) |-> ($past(clk_fall) || timeout_o)); // R3

  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    byte_vld_o |=> !byte_vld_o); // R9

  AST_VLD_ENDS_XFER: assert property (@(posedge clk) disable iff (rst)
    byte_vld_o |-> (!xfer_active_o && $past(xfer_active_o))); // R9

  AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> (host_busy_o && !xfer_active_o && !byte_vld_o)); // R8
endmodule

bind pp_nibble_rx pp_nibble_rx_chk u_chk (
  .clk(clk), .rst(rst), .req_i(req_i), .host_busy_o(host_busy_o),
  .xfer_active_o(xfer_active_o), .byte_vld_o(byte_vld_o),
  .timeout_o(timeout_o), .clk_fall(clk_fall)
);

// File: tb/pp_nibble_rx_bench.sv
module pp_nibble_rx_bench;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic [CW-1:0] lim = 16'd200;
  logic          pclk = 1'b1;
  logic [3:0]    nib = 4'h0;
  logic [7:0]    byte_o;
  logic          byte_vld_o, timeout_o, host_busy_o, xfer_active_o;
  logic          fwd_strobe_n_o, periph_reset_n_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  pp_nibble_rx #(.CNT_W(CW)) u_pp_nibble_rx (
    .clk(clk), .rst(rst), .req_i(req), .timeout_lim_i(lim),
    .byte_o(byte_o), .byte_vld_o(byte_vld_o), .timeout_o(timeout_o),
    .per_clk_i(pclk), .per_nib_i(nib), .host_busy_o(host_busy_o),
    .xfer_active_o(xfer_active_o), .fwd_strobe_n_o(fwd_strobe_n_o),
    .periph_reset_n_o(periph_reset_n_o)
  );

  always #2.5 clk = ~clk;

  // stimulus table: {byte, setup cycles before the clock falls}
  localparam logic [15:0] VEC [8] = '{
    {8'hA5, 8'd1}, {8'h00, 8'd2}, {8'hFF, 8'd3}, {8'h5A, 8'd1},
    {8'h81, 8'd4}, {8'h7E, 8'd2}, {8'h0F, 8'd5}, {8'hF0, 8'd1}
  };

  task automatic chk(input bit ok, input string r, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", r, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_req();
    req = 1'b1;
    step(1);
    req = 1'b0;
  endtask

  task automatic wait_hb(input logic v, output int lat);
    lat = 0;
    while (host_busy_o !== v && lat < 400) begin
      step(1);
      lat++;
    end
  endtask

  task automatic nibble(input logic [3:0] d, input int setup);
    int lat;
    wait_hb(1'b0, lat);
    nib = d;
    step(setup);
    chk(host_busy_o == 1'b0, "R2 busy held low", host_busy_o, 0);
    chk(xfer_active_o == 1'b1, "R1 active during read", xfer_active_o, 1);
    chk(fwd_strobe_n_o && periph_reset_n_o, "R6 unused outputs high",
        {fwd_strobe_n_o, periph_reset_n_o}, 3);
    pclk = 1'b0;
    lat = 0;
    while (!host_busy_o && lat < 20) begin
      step(1);
      lat++;
    end
    chk(lat == 3, "R3 busy rise latency", lat, 3);
    nib = ~d;  // R7: data changes after capture must not matter
    step(2);
    pclk = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] b, input int setup, input bit req_mid);
    int lat;
    nibble(b[3:0], setup);
    if (req_mid) pulse_req();
    nibble(b[7:4], setup);
    lat = 0;
    while (!byte_vld_o && lat < 20) begin
      step(1);
      lat++;
    end
    chk(lat == 3, "R9 valid latency", lat, 3);
    chk(byte_o == b, "R4 R5 R7 byte value", byte_o, b);
    step(1);
    chk(byte_vld_o == 1'b0, "R9 single-cycle valid", byte_vld_o, 0);
    chk(xfer_active_o == 1'b0, "R1 idle after byte", xfer_active_o, 0);
  endtask

  initial begin
    int lat;
    bit saw_vld;
    step(3);
    chk(host_busy_o == 1'b1, "R12 reset busy", host_busy_o, 1);
    chk(xfer_active_o == 1'b0, "R12 reset active", xfer_active_o, 0);
    chk(byte_vld_o == 1'b0 && timeout_o == 1'b0, "R12 reset strobes",
        {byte_vld_o, timeout_o}, 0);
    chk(fwd_strobe_n_o && periph_reset_n_o, "R6 reset outputs",
        {fwd_strobe_n_o, periph_reset_n_o}, 3);
    rst = 1'b0;
    step(2);

    for (int i = 0; i < 8; i++) begin
      pulse_req();
      send_byte(VEC[i][15:8], int'(VEC[i][7:0]), 1'b0);
      step(3);
    end

    // R11: request during a read is ignored
    pulse_req();
    send_byte(8'hC3, 2, 1'b1);
    step(20);
    chk(host_busy_o == 1'b1 && xfer_active_o == 1'b0, "R11 no extra read",
        {host_busy_o, xfer_active_o}, 2);

    // R8: timeout while waiting for the first nibble
    lim = 16'd16;
    pulse_req();
    lat = 0; saw_vld = 0;
    while (!timeout_o && lat < 100) begin
      step(1);
      lat++;
      if (byte_vld_o) saw_vld = 1;
    end
    chk(lat >= 16 && lat <= 20, "R8 timeout latency", lat, 16);
    chk(host_busy_o == 1'b1 && xfer_active_o == 1'b0, "R8 released on timeout",
        {host_busy_o, xfer_active_o}, 2);
    chk(!saw_vld, "R8 no byte on timeout", saw_vld, 0);
    step(1);
    chk(timeout_o == 1'b0, "R8 timeout one cycle", timeout_o, 0);

    // R8: timeout while the peripheral holds its clock low
    pulse_req();
    wait_hb(1'b0, lat);
    nib = 4'h6;
    step(1);
    pclk = 1'b0;
    wait_hb(1'b1, lat);
    lat = 0;
    while (!timeout_o && lat < 100) begin
      step(1);
      lat++;
    end
    chk(timeout_o == 1'b1, "R8 timeout mid byte", timeout_o, 1);
    chk(xfer_active_o == 1'b0, "R8 active drops mid byte", xfer_active_o, 0);
    pclk = 1'b1;
    step(6);

    // R10: limit of zero never times out
    lim = '0;
    pulse_req();
    saw_vld = 0;
    for (int k = 0; k < 300; k++) begin
      step(1);
      if (timeout_o) saw_vld = 1;
    end
    chk(!saw_vld, "R10 no timeout when disabled", saw_vld, 0);
    chk(host_busy_o == 1'b0, "R10 still waiting", host_busy_o, 0);
    send_byte(8'h3C, 2, 1'b0);

    // R12: reset in the middle of a read
    lim = 16'd200;
    pulse_req();
    step(5);
    rst = 1'b1;
    step(2);
    chk(host_busy_o == 1'b1 && xfer_active_o == 1'b0, "R12 mid-read reset",
        {host_busy_o, xfer_active_o}, 2);
    rst = 1'b0;
    step(3);
    pulse_req();
    send_byte(8'h96, 1, 1'b0);

    finish_run();
  end
endmodule